// File: doc/BRIEF.md
# Hot Exit-Point Profiling Counter Cache

This block attributes execution time to the exit points of translated code regions. Each time execution leaves a region, the surrounding logic presents the exit address and the number of cycles charged to that exit. The block looks the address up in a set-associative table of tagged counters. On a hit it adds the cycles to the matching counter. On a miss it claims a way of the set and starts that counter at the incoming cycles. In the same cycle a global register accumulates every accepted increment, so the block always holds the total of profiled time.

An exit counts as hot once its counter reaches a programmable percentage of the total. The test uses cross-multiplication, so no divider is needed. The first time an entry qualifies, the block places its exit address in a one-deep notification slot with a valid/ready handshake. Software can read any entry through a set/way read port and can wipe the table with a clear sequence. The clear walks one set per cycle while a busy flag is high. Counting uses only this dedicated array and never touches the data cache.

Top module: `exit_heat_profiler`

## Requirements
- R1: An accepted update whose tag matches a valid way of the indexed set adds `upd_cycles` to that way's counter. The set index is `upd_addr[ALIGN_W+IDX_W-1:ALIGN_W]` and the tag is the bits above it.
- R2: On a miss, the victim is the way named by the set's round-robin pointer. The pointer starts at way 0 after reset or clear and advances by one on each allocation. The victim gets the new tag and valid=1, and its counter restarts at `upd_cycles`.
- R3: `total_cycles` adds the `upd_cycles` of every accepted update in the same clock edge as the counter update.
- R4: An update is hot when its new counter C is nonzero and C*100 >= `thr_pct`*T, where T is the new total and `thr_pct` is an unsigned integer percentage. A hot update that is accepted into the slot is visible on `hot_valid`/`hot_addr` right after that edge. `hot_addr` carries the full update address.
- R5: An entry raises the notification at most once until it is evicted or the table is cleared. A re-allocated entry starts unreported.
- R6: The slot holds one notification. While `hot_valid` is high and `hot_ready` is low, `hot_addr` stays stable. A hot update that finds the slot full is not marked reported, so a later update of the same entry can raise it.
- R7: Counters saturate at their all-ones value instead of wrapping.
- R8: A `clr_start` pulse sets `busy` for exactly SETS cycles. During that time the block invalidates one set per cycle and zeroes the total at the start. Updates presented while `busy` is high, or in the same cycle as `clr_start`, are ignored.
- R9: A read request on `rd_set`/`rd_way` returns the entry's valid bit, tag and counter on `rd_valid`/`rd_tag`/`rd_count` after one clock edge.
- R10: After reset all entries are invalid, `busy` and `hot_valid` are low and `total_cycles` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Region-exit update strobe |
| upd_addr | input | ADDR_W | Exit-point address |
| upd_cycles | input | INC_W | Cycles charged to this exit |
| thr_pct | input | 7 | Hot threshold in percent |
| clr_start | input | 1 | Start a table clear |
| busy | output | 1 | Clear in progress |
| rd_en | input | 1 | Read request |
| rd_set | input | IDX_W | Set to read |
| rd_way | input | WAY_W | Way to read |
| rd_valid | output | 1 | Valid bit of the read entry |
| rd_tag | output | TAG_W | Tag of the read entry |
| rd_count | output | CNT_W | Counter of the read entry |
| total_cycles | output | TOT_W | Sum of all accepted increments |
| hot_valid | output | 1 | Notification pending |
| hot_ready | input | 1 | Notification consumer ready |
| hot_addr | output | ADDR_W | Address of the hot exit |

## Verification
The main function is driven by a vector table that mixes first touches spread over all sets, repeat hits on a reported exit, and an update that lands exactly on the threshold equality. It also fills a set and then overflows it twice, which separates hit accumulation from round-robin eviction and the exact comparison from an off-by-one. Directed sequences then run the notification path with the consumer stalled, an update with a zero counter, a saturation run of large increments, and updates arriving during a clear. These show apart the retry of an unqueued hot exit, the nonzero guard, saturation against wrapping, and ignored updates against ones that were counted.

// File: rtl/heat_pkg.sv
package heat_pkg;

  localparam int PCT_W    = 7;
  localparam int PCT_FULL = 100;

  // Cross-multiplied share test: cnt/tot >= pct/100 without a divider.
  function automatic logic share_reached(input logic [63:0] cnt,
                                         input logic [63:0] tot,
                                         input logic [PCT_W-1:0] pct);
    logic [71:0] lhs;
    logic [71:0] rhs;
    lhs = {8'd0, cnt} * 72'(PCT_FULL);
    rhs = {8'd0, tot} * {65'd0, pct};
    return lhs >= rhs;
  endfunction

endpackage

// File: rtl/heat_lookup.sv
module heat_lookup #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WAYS-1:0]             set_valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  set_tag,
  input  logic [TAG_W-1:0]            tag_in,
  input  logic [WAY_W-1:0]            rr_ptr,
  output logic                        hit,
  output logic [WAY_W-1:0]            sel_way
);

  logic [WAYS-1:0] hit_vec;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = set_valid[w] && (set_tag[w] == tag_in);
  end

  always_comb begin
    sel_way = rr_ptr;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) sel_way = WAY_W'(w);
    end
  end

  assign hit = |hit_vec;

  // R2: allocation never leaves two ways of a set holding the same tag
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/heat_store.sv
module heat_store #(
  parameter int SETS  = 32,
  parameter int WAYS  = 8,
  parameter int TAG_W = 20,
  parameter int CNT_W = 24,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  // lookup view of one set
  input  logic [IDX_W-1:0]            look_set,
  output logic [WAYS-1:0]             set_valid,
  output logic [WAYS-1:0]             set_rep,
  output logic [WAYS-1:0][TAG_W-1:0]  set_tag,
  output logic [WAYS-1:0][CNT_W-1:0]  set_cnt,
  output logic [WAY_W-1:0]            set_rr,
  // write port
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_set,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic                        wr_alloc,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic [CNT_W-1:0]            wr_cnt,
  input  logic                        wr_rep,
  // clear of one set
  input  logic                        clr_en,
  input  logic [IDX_W-1:0]            clr_set,
  // software read port
  input  logic                        rd_en,
  input  logic [IDX_W-1:0]            rd_set,
  input  logic [WAY_W-1:0]            rd_way,
  output logic                        rd_valid,
  output logic [TAG_W-1:0]            rd_tag,
  output logic [CNT_W-1:0]            rd_count
);

  logic [SETS-1:0][WAYS-1:0]             all_valid;
  logic [SETS-1:0][WAYS-1:0]             all_rep;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  all_tag;
  logic [SETS-1:0][WAYS-1:0][CNT_W-1:0]  all_cnt;
  logic [SETS-1:0][WAY_W-1:0]            all_rr;

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic             set_hit_wr;
    logic             set_hit_clr;
    logic [WAY_W-1:0] rr_q;

    assign set_hit_wr  = wr_en  && (wr_set  == IDX_W'(s));
    assign set_hit_clr = clr_en && (clr_set == IDX_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n || set_hit_clr) rr_q <= '0;
      else if (set_hit_wr && wr_alloc) rr_q <= rr_q + 1'b1;
    end
    assign all_rr[s] = rr_q;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic             v_q;
      logic             r_q;
      logic [TAG_W-1:0] t_q;
      logic [CNT_W-1:0] c_q;
      logic             sel;

      assign sel = set_hit_wr && (wr_way == WAY_W'(w));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          r_q <= 1'b0;
          t_q <= '0;
          c_q <= '0;
        end else if (set_hit_clr) begin
          v_q <= 1'b0;
          r_q <= 1'b0;
        end else if (sel) begin
          v_q <= 1'b1;
          r_q <= wr_rep;
          t_q <= wr_tag;
          c_q <= wr_cnt;
        end
      end

      assign all_valid[s][w] = v_q;
      assign all_rep[s][w]   = r_q;
      assign all_tag[s][w]   = t_q;
      assign all_cnt[s][w]   = c_q;

      // R7: an in-place update never lowers a counter (no wrap)
      a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_alloc && v_q) |-> (wr_cnt >= c_q));
      // R5: a reported entry stays reported until evicted or cleared
      a_r5_sticky_report: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr_alloc && r_q) |-> wr_rep);
    end
  end

  assign set_valid = all_valid[look_set];
  assign set_rep   = all_rep[look_set];
  assign set_tag   = all_tag[look_set];
  assign set_cnt   = all_cnt[look_set];
  assign set_rr    = all_rr[look_set];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_tag   <= '0;
      rd_count <= '0;
    end else if (rd_en) begin
      rd_valid <= all_valid[rd_set][rd_way];
      rd_tag   <= all_tag[rd_set][rd_way];
      rd_count <= all_cnt[rd_set][rd_way];
    end
  end

endmodule

// File: rtl/heat_notify.sv
module heat_notify #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  output logic              slot_free,
  output logic              hot_valid,
  input  logic              hot_ready,
  output logic [ADDR_W-1:0] hot_addr
);

  assign slot_free = !hot_valid || hot_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hot_valid <= 1'b0;
      hot_addr  <= '0;
    end else if (push && slot_free) begin
      hot_valid <= 1'b1;
      hot_addr  <= push_addr;
    end else if (hot_ready) begin
      hot_valid <= 1'b0;
    end
  end

  // R6: a stalled notification holds its address
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_valid && !hot_ready) |=> (hot_valid && $stable(hot_addr)));

endmodule

// File: rtl/exit_heat_profiler.sv
module exit_heat_profiler #(
  parameter int ADDR_W  = 32,
  parameter int ALIGN_W = 2,
  parameter int ENTRIES = 256,
  parameter int WAYS    = 8,
  parameter int CNT_W   = 24,
  parameter int TOT_W   = 32,
  parameter int INC_W   = 16,
  localparam int SETS  = ENTRIES / WAYS,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - ALIGN_W - IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_valid,
  input  logic [ADDR_W-1:0]    upd_addr,
  input  logic [INC_W-1:0]     upd_cycles,
  input  logic [6:0]           thr_pct,
  input  logic                 clr_start,
  output logic                 busy,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     rd_set,
  input  logic [WAY_W-1:0]     rd_way,
  output logic                 rd_valid,
  output logic [TAG_W-1:0]     rd_tag,
  output logic [CNT_W-1:0]     rd_count,
  output logic [TOT_W-1:0]     total_cycles,
  output logic                 hot_valid,
  input  logic                 hot_ready,
  output logic [ADDR_W-1:0]    hot_addr
);

  function automatic logic [CNT_W-1:0] cnt_add(input logic [CNT_W-1:0] a,
                                               input logic [INC_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? '1 : s[CNT_W-1:0];
  endfunction

  function automatic logic [TOT_W-1:0] tot_add(input logic [TOT_W-1:0] a,
                                               input logic [INC_W-1:0] b);
    logic [TOT_W:0] s;
    s = {1'b0, a} + (TOT_W+1)'(b);
    return s[TOT_W] ? '1 : s[TOT_W-1:0];
  endfunction

  // decoded update
  logic [IDX_W-1:0] upd_idx;
  logic [TAG_W-1:0] upd_tag;
  assign upd_idx = upd_addr[ALIGN_W +: IDX_W];
  assign upd_tag = upd_addr[ADDR_W-1 -: TAG_W];

  // clear sequencer
  logic             clr_go;
  logic [IDX_W-1:0] clr_set_q;
  assign clr_go = clr_start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      clr_set_q <= '0;
    end else if (clr_go) begin
      busy      <= 1'b1;
      clr_set_q <= '0;
    end else if (busy) begin
      clr_set_q <= clr_set_q + 1'b1;
      if (clr_set_q == IDX_W'(SETS-1)) busy <= 1'b0;
    end
  end

  // named internal events
  logic                        upd_accept;
  logic [WAYS-1:0]             set_valid;
  logic [WAYS-1:0]             set_rep;
  logic [WAYS-1:0][TAG_W-1:0]  set_tag;
  logic [WAYS-1:0][CNT_W-1:0]  set_cnt;
  logic [WAY_W-1:0]            set_rr;
  logic                        lk_hit;
  logic [WAY_W-1:0]            lk_way;
  logic [CNT_W-1:0]            new_cnt;
  logic [TOT_W-1:0]            new_total;
  logic                        was_reported;
  logic                        hot_event;
  logic                        slot_free;
  logic                        hot_push;
  logic [TOT_W-1:0]            total_q;

  assign upd_accept = upd_valid && !busy && !clr_start;

  heat_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_valid (set_valid),
    .set_tag   (set_tag),
    .tag_in    (upd_tag),
    .rr_ptr    (set_rr),
    .hit       (lk_hit),
    .sel_way   (lk_way)
  );

  assign new_cnt      = cnt_add(lk_hit ? set_cnt[lk_way] : '0, upd_cycles);
  assign new_total    = tot_add(total_q, upd_cycles);
  assign was_reported = lk_hit && set_rep[lk_way];
  assign hot_event    = upd_accept && (new_cnt != '0) && !was_reported &&
                        heat_pkg::share_reached(64'(new_cnt), 64'(new_total), thr_pct);
  assign hot_push     = hot_event && slot_free;

  heat_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_set  (upd_idx),
    .set_valid (set_valid),
    .set_rep   (set_rep),
    .set_tag   (set_tag),
    .set_cnt   (set_cnt),
    .set_rr    (set_rr),
    .wr_en     (upd_accept),
    .wr_set    (upd_idx),
    .wr_way    (lk_way),
    .wr_alloc  (!lk_hit),
    .wr_tag    (upd_tag),
    .wr_cnt    (new_cnt),
    .wr_rep    (was_reported || hot_push),
    .clr_en    (busy),
    .clr_set   (clr_set_q),
    .rd_en     (rd_en),
    .rd_set    (rd_set),
    .rd_way    (rd_way),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_count  (rd_count)
  );

  heat_notify #(.ADDR_W(ADDR_W)) u_notify (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (hot_event),
    .push_addr (upd_addr),
    .slot_free (slot_free),
    .hot_valid (hot_valid),
    .hot_ready (hot_ready),
    .hot_addr  (hot_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clr_go) total_q <= '0;
    else if (upd_accept)  total_q <= new_total;
  end
  assign total_cycles = total_q;

  // R3: outside a clear the total never decreases
  a_r3_total_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_go |=> (total_q >= $past(total_q)));
  // R8: no cycles are counted while a clear walks the table
  a_r8_quiet_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (total_q == '0));
  // R4: a queued notification always comes from a nonzero counter
  a_r4_nonzero_hot: assert property (@(posedge clk) disable iff (!rst_n)
    hot_push |-> (new_cnt != '0));

endmodule

// File: tb/exit_heat_profiler_test.sv
module exit_heat_profiler_test;

  localparam int ADDR_W = 16, ALIGN_W = 2, ENTRIES = 16, WAYS = 4;
  localparam int CNT_W = 12, TOT_W = 16, INC_W = 8;
  localparam int IDX_W = 2, WAY_W = 2, TAG_W = 12;
  localparam int NVEC = 11;

  // {addr, increment, expect hot}
  localparam logic [24:0] VEC [NVEC] = '{
    {16'h0010, 8'd10,  1'b1},   // A set0 alloc w0
    {16'h0104, 8'd10,  1'b1},   // B set1
    {16'h0208, 8'd20,  1'b1},   // C set2
    {16'h030C, 8'd40,  1'b1},   // D set3
    {16'h0010, 8'd10,  1'b0},   // A hit, already reported
    {16'h0020, 8'd10,  1'b0},   // E set0 w1, below share
    {16'h0020, 8'd20,  1'b1},   // E exactly 25%
    {16'h0030, 8'd5,   1'b0},   // F set0 w2
    {16'h0040, 8'd5,   1'b0},   // G set0 w3
    {16'h0050, 8'd200, 1'b1},   // H evicts A (w0)
    {16'h0010, 8'd1,   1'b0}    // A evicts E (w1)
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic upd_valid = 1'b0, clr_start = 1'b0, rd_en = 1'b0, hot_ready = 1'b1;
  logic [ADDR_W-1:0] upd_addr = '0;
  logic [INC_W-1:0]  upd_cycles = '0;
  logic [6:0]        thr_pct = 7'd25;
  logic [IDX_W-1:0]  rd_set = '0;
  logic [WAY_W-1:0]  rd_way = '0;
  logic busy, rd_valid, hot_valid;
  logic [TAG_W-1:0]  rd_tag;
  logic [CNT_W-1:0]  rd_count;
  logic [TOT_W-1:0]  total_cycles;
  logic [ADDR_W-1:0] hot_addr;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  exit_heat_profiler #(.ADDR_W(ADDR_W), .ALIGN_W(ALIGN_W), .ENTRIES(ENTRIES),
    .WAYS(WAYS), .CNT_W(CNT_W), .TOT_W(TOT_W), .INC_W(INC_W)) uut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_addr(upd_addr),
    .upd_cycles(upd_cycles), .thr_pct(thr_pct), .clr_start(clr_start),
    .busy(busy), .rd_en(rd_en), .rd_set(rd_set), .rd_way(rd_way),
    .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_count(rd_count),
    .total_cycles(total_cycles), .hot_valid(hot_valid), .hot_ready(hot_ready),
    .hot_addr(hot_addr));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic update(input logic [15:0] a, input logic [7:0] inc);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_cycles = inc;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic read_entry(input int s, input int w);
    @(negedge clk);
    rd_en = 1'b1; rd_set = IDX_W'(s); rd_way = WAY_W'(w);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic clear_table();
    @(negedge clk); clr_start = 1'b1;
    @(negedge clk); clr_start = 1'b0;
    repeat (WAYS) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", 32'(busy), 0);
    check("R10 hot_valid", 32'(hot_valid), 0);
    check("R10 total", 32'(total_cycles), 0);
    read_entry(2, 3);
    check("R10 entry invalid", 32'(rd_valid), 0);

    // Table walk: R1 R2 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      update(VEC[i][24:9], VEC[i][8:1]);
      check("R4 hot_valid", 32'(hot_valid), 32'(VEC[i][0]));
      if (VEC[i][0]) check("R4 hot_addr", 32'(hot_addr), 32'(VEC[i][24:9]));
    end
    check("R3 total", 32'(total_cycles), 331);
    read_entry(0, 0);
    check("R2 evict valid", 32'(rd_valid), 1);
    check("R2 evict tag", 32'(rd_tag), 12'h005);
    check("R2 evict count", 32'(rd_count), 200);
    read_entry(0, 1);
    check("R2 realloc tag", 32'(rd_tag), 12'h001);
    check("R2 realloc count", 32'(rd_count), 1);
    read_entry(0, 2);
    check("R9 read count", 32'(rd_count), 5);
    read_entry(1, 0);
    check("R1 hit tag", 32'(rd_tag), 12'h010);
    check("R1 hit count", 32'(rd_count), 10);
    read_entry(3, 1);
    check("R9 unused invalid", 32'(rd_valid), 0);
    read_entry(0, 3);
    check("R1 count G", 32'(rd_count), 5);

    // R6 backpressure and retry
    clear_table();
    thr_pct = 7'd50; hot_ready = 1'b0;
    update(16'h0004, 8'd10);
    check("R6 first hot", 32'(hot_valid), 1);
    update(16'h0008, 8'd10);
    check("R6 stalled valid", 32'(hot_valid), 1);
    check("R6 stalled addr", 32'(hot_addr), 16'h0004);
    @(negedge clk); hot_ready = 1'b1;
    @(negedge clk); hot_ready = 1'b0;
    check("R6 drained", 32'(hot_valid), 0);
    update(16'h0008, 8'd0);
    check("R6 retry valid", 32'(hot_valid), 1);
    check("R6 retry addr", 32'(hot_addr), 16'h0008);
    hot_ready = 1'b1;
    @(negedge clk);
    update(16'h0004, 8'd10);
    check("R5 no repeat", 32'(hot_valid), 0);

    // R4 zero-counter guard
    clear_table();
    thr_pct = 7'd5;
    update(16'h000C, 8'd0);
    check("R4 zero not hot", 32'(hot_valid), 0);

    // R7 saturation
    for (int k = 0; k < 17; k++) update(16'h0100, 8'd255);
    read_entry(0, 0);
    check("R7 saturated", 32'(rd_count), 4095);
    check("R3 total sum", 32'(total_cycles), 4335);

    // R8 clear timing and ignored updates
    @(negedge clk); clr_start = 1'b1;
    upd_valid = 1'b1; upd_addr = 16'h0204; upd_cycles = 8'd3;
    @(negedge clk); clr_start = 1'b0; upd_valid = 1'b0;
    check("R8 busy c1", 32'(busy), 1);
    @(negedge clk);
    check("R8 busy c2", 32'(busy), 1);
    upd_valid = 1'b1; upd_addr = 16'h0100; upd_cycles = 8'd9;
    @(negedge clk); upd_valid = 1'b0;
    check("R8 busy c3", 32'(busy), 1);
    @(negedge clk);
    check("R8 busy c4", 32'(busy), 1);
    @(negedge clk);
    check("R8 busy end", 32'(busy), 0);
    check("R8 total zero", 32'(total_cycles), 0);
    read_entry(0, 0);
    check("R8 set0 empty", 32'(rd_valid), 0);
    read_entry(1, 0);
    check("R8 set1 empty", 32'(rd_valid), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule